// File: doc/BRIEF.md
# Dual 16-bit Timer/Counter

This block holds two independent 16-bit timer/counters, each kept as a low byte and a high byte. Each unit advances from one of two sources. The first is a shared divide-by-twelve tick taken from the system clock. The second is a falling edge on that unit's own count pin, found by sampling the pin on every clock and comparing the last two samples. A per-unit gate pin can hold counting off while the gate option is selected. Each unit runs either as a plain 16-bit counter or as an 8-bit counter whose low byte reloads from the high byte whenever it wraps.

Software reaches the four counter bytes, a shared mode register and a control register through a single-cycle register port. Writes take effect at the next clock edge and reads are combinational. The port has no valid/ready handshake and never stalls, so there is no back-pressure. Every access completes in the cycle it is presented.

Each overflow raises a sticky flag for an interrupt controller. The overflow of unit 1 also produces a one-clock pulse that a serial port can use as its baud source.

Top module: `dual_tick_counter`

## Requirements
- R1: After reset, all four counter bytes, the mode register, the control register, both overflow flags and `baud_tick` read as zero.
- R2: Register map on `reg_addr`: 0 = unit 0 low, 1 = unit 0 high, 2 = unit 1 low, 3 = unit 1 high, 4 = mode, 5 = control. Each written value reads back. Control bits [1:0] are the run bits of units 1..0 and read back as written. Control bits [3:2] read as the overflow flags of units 1..0.
- R3: When the counter-source bit is 0 and the unit is enabled, the count rises by exactly one per 12 clocks. Over any 120 consecutive clocks it rises by exactly 10.
- R4: When the counter-source bit is 1, each falling edge on the unit's `cnt_pin` bit adds one, visible two clock edges after the pin falls. Rising edges and steady levels add nothing.
- R5: A unit counts only while its run bit is 1 and either its gate bit is 0 or its `gate_pin` bit is high. With the gate bit 0, the gate pin has no effect.
- R6: Mode nibble: unit 0 uses mode[3:0] and unit 1 uses mode[7:4]. Within a nibble, bit 3 is gate, bit 2 is the counter-source select and bits [1:0] are the mode. Mode 01 counts as 16 bits and wraps from FFFF to 0000, which sets the unit's overflow flag.
- R7: In mode 10, the low byte wraps from FF by loading the high byte. The high byte is unchanged and the overflow flag is set.
- R8: An overflow flag stays set until one of two things clears it. The first is a one-clock pulse on that unit's `irq_ack` bit. The second is a control write with a 1 in that unit's flag bit. A new overflow in the same cycle wins over a clear. An ack for the other unit has no effect.
- R9: Each overflow of unit 1 produces a single one-clock pulse on `baud_tick`, one edge after the wrap.
- R10: Modes 00 and 11 hold the count unchanged whatever the source does.
- R11: A write to either byte of a unit in a cycle where that unit would increment takes the written value and drops that increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one access per clock |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| cnt_pin | input | 2 | External count inputs, bit i for unit i |
| gate_pin | input | 2 | External gate inputs, bit i for unit i |
| irq_ack | input | 2 | Flag clear pulses from the interrupt controller |
| ovf_flag | output | 2 | Sticky overflow flags |
| baud_tick | output | 1 | One-clock pulse per unit 1 overflow |

## Verification
Assertions check several properties on every cycle:
- the prescaler never ticks on two clocks in a row;
- a stopped unit with no write holds its count;
- a wrap in mode 10 loads the high byte into the low byte;
- a flag with no clear request stays set;
- `baud_tick` only appears with the unit 1 flag up and never lasts two clocks.

Only the bench scenarios can show the rest: the exact divide ratio over a long window, the two-edge latency of pin edges, gate pins being ignored when the gate bit is clear, the hold modes, and a byte write overriding a simultaneous increment.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int BYTE_W = 8;
  localparam int NUM_UNITS = 2;

  typedef enum logic [1:0] {
    MD_HOLD_A = 2'b00,
    MD_WIDE   = 2'b01,
    MD_RELOAD = 2'b10,
    MD_HOLD_B = 2'b11
  } unit_mode_e;

  typedef struct packed {
    logic       gate;
    logic       ext_src;
    unit_mode_e mode;
  } unit_cfg_t;

  localparam logic [2:0] RA_MODE = 3'd4;
  localparam logic [2:0] RA_CTRL = 3'd5;
endpackage

// File: rtl/dtc_prescale.sv
module dtc_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase_q;

  assign tick = (phase_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    phase_q <= '0;
    else if (tick) phase_q <= '0;
    else           phase_q <= phase_q + 1'b1;
  end

  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  p_phase_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST);
endmodule

// File: rtl/dtc_fall_detect.sv
module dtc_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic samp_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      samp_q <= pin;
      prev_q <= samp_q;
    end
  end

  assign fall = prev_q & ~samp_q;

  p_fall_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/dtc_timer.sv
module dtc_timer
  import dtc_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  unit_cfg_t    cfg,
  input  logic         run,
  input  logic         gate_in,
  input  logic         tick,
  input  logic         fall,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi,
  output logic         ovf
);
  logic enable, src_evt, counting, bump, lo_full, all_full;

  assign enable   = run & (~cfg.gate | gate_in);
  assign src_evt  = cfg.ext_src ? fall : tick;
  assign counting = (cfg.mode == MD_WIDE) || (cfg.mode == MD_RELOAD);
  assign bump     = enable & src_evt & counting & ~wr_lo & ~wr_hi;
  assign lo_full  = (lo == {W{1'b1}});
  assign all_full = lo_full & (hi == {W{1'b1}});
  assign ovf      = bump & ((cfg.mode == MD_WIDE) ? all_full : lo_full);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      if (wr_lo)
        lo <= wdata;
      else if (bump)
        lo <= (cfg.mode == MD_RELOAD && lo_full) ? hi : lo + 1'b1;
      if (wr_hi)
        hi <= wdata;
      else if (bump && cfg.mode == MD_WIDE && lo_full)
        hi <= hi + 1'b1;
    end
  end

  p_hold_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_lo && !wr_hi) |=> ($stable(lo) && $stable(hi)));
  p_hold_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!counting && !wr_lo && !wr_hi) |=> ($stable(lo) && $stable(hi)));
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && cfg.mode == MD_RELOAD && lo_full) |=> (lo == $past(hi) && $stable(hi)));
  p_wide_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && cfg.mode == MD_WIDE) |=> (lo == '0 && hi == '0));
endmodule

// File: rtl/dual_tick_counter.sv
module dual_tick_counter
  import dtc_pkg::*;
#(
  parameter int DIV = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           reg_addr,
  input  logic [BYTE_W-1:0]    reg_wdata,
  input  logic                 reg_wr,
  output logic [BYTE_W-1:0]    reg_rdata,
  input  logic [NUM_UNITS-1:0] cnt_pin,
  input  logic [NUM_UNITS-1:0] gate_pin,
  input  logic [NUM_UNITS-1:0] irq_ack,
  output logic [NUM_UNITS-1:0] ovf_flag,
  output logic                 baud_tick
);
  localparam int NIB = BYTE_W / NUM_UNITS;

  logic                 tick;
  logic [BYTE_W-1:0]    mode_q;
  logic [NUM_UNITS-1:0] run_q, flag_q, ovf_v, fall_v, clr_v;
  logic                 baud_q;
  logic                 ctrl_wr;
  logic [BYTE_W-1:0]    lo_v [NUM_UNITS];
  logic [BYTE_W-1:0]    hi_v [NUM_UNITS];

  assign ctrl_wr = reg_wr && (reg_addr == RA_CTRL);

  dtc_prescale #(.DIV(DIV)) u_pre (.clk(clk), .rst_n(rst_n), .tick(tick));

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
    logic wr_lo, wr_hi;
    assign wr_lo = reg_wr && (reg_addr == 3'(2 * i));
    assign wr_hi = reg_wr && (reg_addr == 3'(2 * i + 1));
    assign clr_v[i] = irq_ack[i] | (ctrl_wr & reg_wdata[NUM_UNITS + i]);

    dtc_fall_detect u_edge (
      .clk(clk), .rst_n(rst_n), .pin(cnt_pin[i]), .fall(fall_v[i])
    );

    dtc_timer #(.W(BYTE_W)) u_tmr (
      .clk(clk), .rst_n(rst_n),
      .cfg(unit_cfg_t'(mode_q[NIB*i +: NIB])),
      .run(run_q[i]), .gate_in(gate_pin[i]),
      .tick(tick), .fall(fall_v[i]),
      .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(reg_wdata),
      .lo(lo_v[i]), .hi(hi_v[i]), .ovf(ovf_v[i])
    );

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !clr_v[i]) |=> flag_q[i]);
    p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_v[i] |=> flag_q[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
      baud_q <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == RA_MODE) mode_q <= reg_wdata;
      if (ctrl_wr) run_q <= reg_wdata[NUM_UNITS-1:0];
      for (int k = 0; k < NUM_UNITS; k++) begin
        if (ovf_v[k])      flag_q[k] <= 1'b1;
        else if (clr_v[k]) flag_q[k] <= 1'b0;
      end
      baud_q <= ovf_v[NUM_UNITS-1];
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = lo_v[0];
      3'd1:    reg_rdata = hi_v[0];
      3'd2:    reg_rdata = lo_v[1];
      3'd3:    reg_rdata = hi_v[1];
      RA_MODE: reg_rdata = mode_q;
      RA_CTRL: reg_rdata = {{(BYTE_W - 2*NUM_UNITS){1'b0}}, flag_q, run_q};
      default: reg_rdata = '0;
    endcase
  end

  assign ovf_flag  = flag_q;
  assign baud_tick = baud_q;

  p_baud_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> ovf_flag[NUM_UNITS-1]);
  p_baud_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);
endmodule

// File: tb/sim_dual_tick_counter.sv
module sim_dual_tick_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_rdata;
  logic [1:0] cnt_pin = 2'b11;
  logic [1:0] gate_pin = 2'b00;
  logic [1:0] irq_ack = 2'b00;
  logic [1:0] ovf_flag;
  logic       baud_tick;

  int checks = 0;
  int errors = 0;
  int baud_cnt = 0;
  int baud_wide = 0;
  bit baud_prev = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_tick_counter u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .irq_ack(irq_ack), .ovf_flag(ovf_flag),
    .baud_tick(baud_tick)
  );

  always @(negedge clk) begin
    if (baud_tick) begin
      baud_cnt++;
      if (baud_prev) baud_wide++;
    end
    baud_prev = baud_tick;
  end

  // fields: [47] unit, [46] gate pin level, [45] expected flag, [43:40] mode nibble,
  // [39:32] preset hi, [31:24] preset lo, [23:16] falling edges, [15:8] exp hi, [7:0] exp lo
  localparam int NV = 10;
  localparam logic [47:0] VEC [NV] = '{
    {4'b0100, 4'h5, 8'h00, 8'h00, 8'd3, 8'h00, 8'h03},
    {4'b0100, 4'h5, 8'h00, 8'hFE, 8'd3, 8'h01, 8'h01},
    {4'b1110, 4'h5, 8'hFF, 8'hFE, 8'd3, 8'h00, 8'h01},
    {4'b0110, 4'h6, 8'h80, 8'hFE, 8'd3, 8'h80, 8'h81},
    {4'b1110, 4'h6, 8'h10, 8'hFF, 8'd1, 8'h10, 8'h10},
    {4'b0100, 4'h4, 8'h12, 8'h34, 8'd5, 8'h12, 8'h34},
    {4'b1100, 4'h7, 8'h55, 8'h66, 8'd2, 8'h55, 8'h66},
    {4'b0000, 4'hD, 8'h00, 8'h05, 8'd4, 8'h00, 8'h05},
    {4'b1100, 4'hD, 8'h00, 8'h05, 8'd4, 8'h00, 8'h09},
    {4'b1000, 4'h5, 8'h00, 8'h05, 8'd4, 8'h00, 8'h09}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.1;
    d = reg_rdata;
  endtask

  task automatic pulse(input int u);
    cnt_pin[u] = 1'b0;
    repeat (3) @(negedge clk);
    cnt_pin[u] = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] a, b;
    repeat (4) @(negedge clk);
    // R1: reset state, sampled while reset is still applied
    for (int r = 0; r < 6; r++) begin
      rd(3'(r), a);
      chk("R1 reset register", a, 0);
    end
    chk("R1 reset flags", ovf_flag, 0);
    chk("R1 reset baud", baud_tick, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: readback of every register
    wr(3'd0, 8'h3C); wr(3'd1, 8'hC3); wr(3'd2, 8'h5A); wr(3'd3, 8'hA5); wr(3'd4, 8'h96);
    rd(3'd0, a); chk("R2 unit0 lo", a, 8'h3C);
    rd(3'd1, a); chk("R2 unit0 hi", a, 8'hC3);
    rd(3'd2, a); chk("R2 unit1 lo", a, 8'h5A);
    rd(3'd3, a); chk("R2 unit1 hi", a, 8'hA5);
    rd(3'd4, a); chk("R2 mode", a, 8'h96);
    wr(3'd4, 8'h00);
    wr(3'd5, 8'h03); rd(3'd5, a); chk("R2 control run bits", a, 8'h03);
    wr(3'd5, 8'h00);

    // Vector table: counter-source cases covering R4 R5 R6 R7 R10
    for (int v = 0; v < NV; v++) begin
      automatic int u = int'(VEC[v][47]);
      automatic logic [2:0] la = 3'(2 * u);
      wr(3'd5, 8'h0C);
      wr(3'd4, u ? {VEC[v][43:40], 4'h0} : {4'h0, VEC[v][43:40]});
      wr(la + 3'd1, VEC[v][39:32]);
      wr(la, VEC[v][31:24]);
      gate_pin[u] = VEC[v][46];
      wr(3'd5, u ? 8'h02 : 8'h01);
      for (int p = 0; p < int'(VEC[v][23:16]); p++) pulse(u);
      repeat (4) @(negedge clk);
      wr(3'd5, 8'h00);
      rd(la, a);        chk($sformatf("R4 vector %0d lo", v), a, VEC[v][7:0]);
      rd(la + 3'd1, a); chk($sformatf("R7 vector %0d hi", v), a, VEC[v][15:8]);
      rd(3'd5, a);      chk($sformatf("R6 vector %0d flag", v), a[2 + u], VEC[v][45]);
      gate_pin[u] = 1'b0;
    end
    // R9: vectors 2 and 4 wrap unit 1
    chk("R9 baud pulse count", baud_cnt, 2);
    wr(3'd5, 8'h0C);

    // R3: timer source divides by twelve
    wr(3'd4, 8'h01); wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd5, 8'h01);
    rd(3'd0, a);
    repeat (119) @(negedge clk);
    rd(3'd0, b);
    chk("R3 ticks in 120 clocks", 8'(b - a), 10);
    // R5: run bit clear stops timer
    wr(3'd5, 8'h00);
    rd(3'd0, a);
    repeat (119) @(negedge clk);
    rd(3'd0, b);
    chk("R5 stopped unit holds", 8'(b - a), 0);

    // R8: sticky flag, ack pulse, other-unit ack, W1C clear
    wr(3'd4, 8'h05); wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd5, 8'h01);
    pulse(0);
    repeat (20) @(negedge clk);
    chk("R8 flag sticky", ovf_flag[0], 1);
    irq_ack[1] = 1'b1; @(negedge clk); irq_ack[1] = 1'b0;
    chk("R8 other ack ignored", ovf_flag[0], 1);
    irq_ack[0] = 1'b1; @(negedge clk); irq_ack[0] = 1'b0;
    chk("R8 ack clears flag", ovf_flag[0], 0);
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
    pulse(0);
    chk("R8 flag set again", ovf_flag[0], 1);
    wr(3'd5, 8'h05);
    rd(3'd5, a); chk("R8 write-one clears flag", a[2], 0);

    // R11: write to hi in the same cycle as an increment
    wr(3'd0, 8'h10); wr(3'd1, 8'h00);
    @(negedge clk); cnt_pin[0] = 1'b0;
    @(negedge clk); reg_addr = 3'd1; reg_wdata = 8'h40; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    cnt_pin[0] = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd0, a); chk("R11 increment dropped", a, 8'h10);
    rd(3'd1, a); chk("R11 write taken", a, 8'h40);
    wr(3'd5, 8'h0C);

    chk("R9 baud never wide", baud_wide, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule